// File: doc/BRIEF.md
# Serial Display Write Receiver

This block is the write-only serial front end of a display controller. A host drives a serial clock, a data line, an active-low select and, in one of the two framings, a data-or-command line. The receiver assembles bytes most significant bit first. It hands each finished byte to the controller core with a one-cycle strobe and a flag that marks the byte as pixel data or as a command. There is no path for reading back.

A static input picks the framing.

- **Sideband mode:** each byte is eight clocks long. The data-or-command line is looked at only on the eighth clock.
- **In-band mode:** each transfer is nine clocks long. The first bit carries the data-or-command selection and the eight payload bits follow it.

All serial pins are brought into the core clock through synchronising flops, so the core clock must run at least four times faster than the serial clock. Several bytes may follow one another within one select-low period. Raising the select throws away any half-received byte.

Top module: `serial_wr_rx`

## Requirements
- R1: The data line is sampled on each rising edge of the serial clock, and the first sampled bit of the payload lands in `rx_byte_o[7]` and the last in `rx_byte_o[0]`.
- R2: With `three_wire_i`=0, a byte completes on the eighth rising edge. `rx_is_data_o` takes the level of `dc_i` at that edge: 1 means data, 0 means command. The level of `dc_i` on the first seven edges has no effect.
- R3: With `three_wire_i`=1, a byte completes on the ninth rising edge, and the payload is the last eight bits sampled.
- R4: With `three_wire_i`=1, the first bit of a transfer sets `rx_is_data_o` (1 = data, 0 = command), and `dc_i` has no effect.
- R5: Serial clock edges while `cs_n_i` is high produce no strobe and advance no frame.
- R6: `cs_n_i` going high discards a partially received byte. The next transfer starts again at its first bit.
- R7: Back-to-back bytes within one select-low period are each delivered, with the bit position restarting after every completed byte.
- R8: `rx_valid_o` is high for exactly one core cycle per completed byte. `rx_byte_o` and `rx_is_data_o` hold their values until the next strobe.
- R9: While `rst_n` is low, `rx_valid_o`, `rx_byte_o` and `rx_is_data_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| three_wire_i | input | 1 | Static framing select: 1 = nine-bit in-band, 0 = eight-bit with sideband line |
| sclk_i | input | 1 | Serial clock from host, asynchronous |
| sdin_i | input | 1 | Serial data from host |
| cs_n_i | input | 1 | Active-low select |
| dc_i | input | 1 | Sideband data-or-command line (1 = data) |
| rx_byte_o | output | 8 | Last completed byte |
| rx_is_data_o | output | 1 | 1 = data byte, 0 = command byte |
| rx_valid_o | output | 1 | One-cycle strobe per completed byte |

## Verification
The bench toggles `dc_i` against its final value on every non-final bit. A receiver that latched the line early, or that read it in in-band mode, would therefore flag the wrong byte type. It aborts transfers part-way by raising the select and then sends a clean byte. A design that kept its bit count would deliver a byte that is shifted or arrives early. It also clocks while deselected, which would produce spurious strobes, and it sends bursts of bytes under one select, which would expose a counter that fails to wrap. Random bytes in both framings catch bit-order and off-by-one errors in the ninth-bit handling.

// File: rtl/serial_wr_rx.sv
module serial_wr_rx #(
  parameter int SYNC_STAGES = 2,
  parameter int BYTE_W      = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              three_wire_i,
  input  logic              sclk_i,
  input  logic              sdin_i,
  input  logic              cs_n_i,
  input  logic              dc_i,
  output logic [BYTE_W-1:0] rx_byte_o,
  output logic              rx_is_data_o,
  output logic              rx_valid_o
);
  localparam int CNT_W = $clog2(BYTE_W + 1);

  logic [SYNC_STAGES-1:0] sclk_sy, sdin_sy, cs_sy, dc_sy;
  logic sclk_d;
  logic [CNT_W-1:0] cnt;
  logic [BYTE_W-1:0] shreg;
  logic sel_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sclk_sy <= '0;
      sdin_sy <= '0;
      cs_sy   <= '1;
      dc_sy   <= '0;
      sclk_d  <= 1'b0;
    end else begin
      sclk_sy <= {sclk_sy[SYNC_STAGES-2:0], sclk_i};
      sdin_sy <= {sdin_sy[SYNC_STAGES-2:0], sdin_i};
      cs_sy   <= {cs_sy[SYNC_STAGES-2:0], cs_n_i};
      dc_sy   <= {dc_sy[SYNC_STAGES-2:0], dc_i};
      sclk_d  <= sclk_sy[SYNC_STAGES-1];
    end
  end

  wire sclk_s = sclk_sy[SYNC_STAGES-1];
  wire sdin_s = sdin_sy[SYNC_STAGES-1];
  wire cs_s   = cs_sy[SYNC_STAGES-1];
  wire dc_s   = dc_sy[SYNC_STAGES-1];

  wire rise = sclk_s & ~sclk_d & ~cs_s;
  wire last = three_wire_i ? (cnt == CNT_W'(BYTE_W)) : (cnt == CNT_W'(BYTE_W - 1));
  wire [BYTE_W-1:0] next_byte = {shreg[BYTE_W-2:0], sdin_s};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt          <= '0;
      shreg        <= '0;
      sel_q        <= 1'b0;
      rx_byte_o    <= '0;
      rx_is_data_o <= 1'b0;
      rx_valid_o   <= 1'b0;
    end else begin
      rx_valid_o <= rise & last;
      if (cs_s) begin
        cnt <= '0;
      end else if (rise) begin
        shreg <= next_byte;
        cnt   <= last ? '0 : cnt + 1'b1;
        if (three_wire_i && cnt == '0) sel_q <= sdin_s;
        if (last) begin
          rx_byte_o    <= next_byte;
          rx_is_data_o <= three_wire_i ? sel_q : dc_s;
        end
      end
    end
  end
endmodule

// File: rtl/serial_wr_rx_chk.sv
module serial_wr_rx_chk #(
  parameter int BYTE_W = 8,
  parameter int CNT_W  = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             three_wire,
  input logic             cs_s,
  input logic [CNT_W-1:0] cnt,
  input logic             strobe
);
  p_single_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    strobe |=> !strobe);

  p_no_strobe_deselected_r5: assert property (@(posedge clk) disable iff (!rst_n)
    strobe |-> !$past(cs_s));

  p_cs_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cs_s |=> cnt == '0);

  p_cnt_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= (three_wire ? CNT_W'(BYTE_W) : CNT_W'(BYTE_W - 1)));

  p_strobe_on_last_r2: assert property (@(posedge clk) disable iff (!rst_n)
    strobe |-> $past(cnt) == (three_wire ? CNT_W'(BYTE_W) : CNT_W'(BYTE_W - 1)));
endmodule

bind serial_wr_rx serial_wr_rx_chk #(.BYTE_W(BYTE_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .three_wire(three_wire_i),
  .cs_s(cs_s), .cnt(cnt), .strobe(rx_valid_o)
);

// File: tb/test_serial_wr_rx.sv
module test_serial_wr_rx;
  logic clk = 1'b0, rst_n = 1'b0;
  logic three_wire = 1'b0, sclk = 1'b0, sdin = 1'b0, cs_n = 1'b1, dc = 1'b0;
  logic [7:0] rx_byte;
  logic rx_is_data, rx_valid;
  int checks = 0, failures = 0, nstrobe = 0, exp_strobe = 0;
  logic [7:0] got_byte = '0;
  logic got_dc = 1'b0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  serial_wr_rx i_serial_wr_rx (
    .clk(clk), .rst_n(rst_n), .three_wire_i(three_wire), .sclk_i(sclk),
    .sdin_i(sdin), .cs_n_i(cs_n), .dc_i(dc), .rx_byte_o(rx_byte),
    .rx_is_data_o(rx_is_data), .rx_valid_o(rx_valid)
  );

  always @(negedge clk) if (rst_n && rx_valid) begin
    nstrobe++;
    got_byte = rx_byte;
    got_dc = rx_is_data;
  end

  function automatic bit pick_dc(input bit sel, input bit is_last);
    return is_last ? sel : ~sel;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic clk_bit(input bit d, input bit dcv);
    sdin = d; dc = dcv;
    repeat (4) @(negedge clk);
    sclk = 1'b1;
    repeat (4) @(negedge clk);
    sclk = 1'b0;
  endtask

  task automatic sel(input bit low);
    cs_n = ~low;
    repeat (4) @(negedge clk);
  endtask

  task automatic frame4(input logic [7:0] b, input bit dv);
    for (int i = 7; i >= 0; i--) clk_bit(b[i], pick_dc(dv, i == 0));
    repeat (2) @(negedge clk);
  endtask

  task automatic frame3(input logic [7:0] b, input bit dv);
    clk_bit(dv, ~dv);
    for (int i = 7; i >= 0; i--) clk_bit(b[i], ~dv);
    repeat (2) @(negedge clk);
  endtask

  task automatic expect_rx(input string tag, input logic [7:0] b, input bit dv);
    exp_strobe++;
    chk({tag, " strobe count (R8)"}, nstrobe, exp_strobe);
    chk({tag, " byte (R1)"}, got_byte, b);
    chk({tag, " type"}, got_dc, dv);
  endtask

  task automatic finish_run;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    logic [7:0] b;
    bit dv;
    void'($urandom(32'd1306));
    repeat (5) @(negedge clk);
    chk("R9 valid in reset", rx_valid, 0);
    chk("R9 byte in reset", rx_byte, 0);
    chk("R9 type in reset", rx_is_data, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 R2 directed, sideband mode
    sel(1); frame4(8'hA5, 1'b1); sel(0); expect_rx("R2 data A5", 8'hA5, 1'b1);
    sel(1); frame4(8'h80, 1'b0); sel(0); expect_rx("R2 cmd 80", 8'h80, 1'b0);
    sel(1); frame4(8'h01, 1'b1); sel(0); expect_rx("R1 lsb 01", 8'h01, 1'b1);

    // R5: clocks while deselected
    for (int i = 0; i < 8; i++) clk_bit(1'b1, 1'b1);
    repeat (4) @(negedge clk);
    chk("R5 no strobe deselected", nstrobe, exp_strobe);
    sel(1); frame4(8'h3C, 1'b0); sel(0); expect_rx("R5 after idle", 8'h3C, 1'b0);

    // R6: partial discard
    sel(1);
    for (int i = 0; i < 5; i++) clk_bit(1'b1, 1'b1);
    sel(0);
    chk("R6 no strobe partial", nstrobe, exp_strobe);
    sel(1); frame4(8'h12, 1'b1); sel(0); expect_rx("R6 clean after abort", 8'h12, 1'b1);

    // R7: burst under one select
    sel(1);
    frame4(8'hDE, 1'b0); expect_rx("R7 burst0", 8'hDE, 1'b0);
    frame4(8'hAD, 1'b1); expect_rx("R7 burst1", 8'hAD, 1'b1);
    frame4(8'hBE, 1'b0); expect_rx("R7 burst2", 8'hBE, 1'b0);
    sel(0);
    repeat (10) @(negedge clk);
    chk("R8 byte held", rx_byte, 8'hBE);

    for (int n = 0; n < 20; n++) begin
      b = 8'($urandom); dv = 1'($urandom);
      sel(1); frame4(b, dv); sel(0); expect_rx("R2 random", b, dv);
    end

    // in-band mode, switched while deselected
    three_wire = 1'b1;
    repeat (4) @(negedge clk);
    sel(1); frame3(8'h5A, 1'b1); sel(0); expect_rx("R4 data 5A", 8'h5A, 1'b1);
    sel(1); frame3(8'hFF, 1'b0); sel(0); expect_rx("R4 cmd FF", 8'hFF, 1'b0);

    // R3: eight clocks alone do not complete
    sel(1);
    for (int i = 0; i < 8; i++) clk_bit(1'b0, 1'b1);
    repeat (4) @(negedge clk);
    chk("R3 no strobe at eighth", nstrobe, exp_strobe);
    clk_bit(1'b1, 1'b1);
    repeat (2) @(negedge clk);
    sel(0);
    expect_rx("R3 ninth completes", 8'h01, 1'b0);

    sel(1);
    for (int i = 0; i < 6; i++) clk_bit(1'b1, 1'b0);
    sel(0);
    chk("R6 in-band partial", nstrobe, exp_strobe);
    sel(1); frame3(8'h69, 1'b0); sel(0); expect_rx("R6 in-band clean", 8'h69, 1'b0);

    sel(1);
    frame3(8'hC3, 1'b1); expect_rx("R7 in-band burst0", 8'hC3, 1'b1);
    frame3(8'h0F, 1'b0); expect_rx("R7 in-band burst1", 8'h0F, 1'b0);
    sel(0);

    for (int n = 0; n < 20; n++) begin
      b = 8'($urandom); dv = 1'($urandom);
      sel(1); frame3(b, dv); sel(0); expect_rx("R4 random", b, dv);
    end

    finished = 1'b1;
    finish_run();
  end
endmodule